// File: doc/BRIEF.md
# Parallel Flash Bus Command Interface

This block is the bus-facing control logic of a byte-wide parallel flash with a 17-bit address. It watches the active-low chip-enable, output-enable and write-enable strobes on a fast system clock. From them it works out whether the bus is reading, idle with outputs off, in standby, or writing. It drives the enable of the tri-state data pins. It also follows the multi-cycle unlock handshake that must come before a byte program.

A byte program takes four write cycles, in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, and then the target address with its data byte. When the sequence completes, the block sends a single-clock request with that address and byte to an external array port. The block has no reset command. Any write cycle that does not fit the next expected step drops the sequence and puts the block back in read mode.

An 8 KB boot block (16 sectors of 512 bytes) can be locked, and while it is locked, programs aimed inside it are discarded. A parameter places the boot block either at the top (1E000h–1FFFFh) or at the bottom (00000h–01FFFh) of the address space.

Top module: `pflash_bus_ctrl`

## Requirements
- R1: `rd_drive` goes high only while CE is low, OE is low and WE is high, and only if WE was already high when CE and OE became jointly low. If WE drops during the read, `rd_drive` stays low until CE or OE returns high.
- R2: Once CE or OE returns high, `rd_drive` falls within four clocks of the strobe change.
- R3: While CE is high, `rd_drive` is low whatever the level of OE (standby).
- R4: In a write cycle (CE and WE both low), the address is taken when the later of the two strobes falls. The data is taken when the earlier of the two rises. The cycle works the same whether WE or CE is the strobe that falls last and rises first.
- R5: The four write cycles 5555h/AAh, 2AAAh/55h, 5555h/A0h, then target A with data D, produce exactly one single-clock `pgm_req` pulse with `pgm_addr`=A and `pgm_data`=D. The sequencer then goes back to read mode.
- R6: A write cycle that fails to match the expected step ends the partial sequence. One example is 5555h/FFh. After such a cycle, a full four-cycle sequence is needed again before any request is made.
- R7: If a sequence stops after the setup cycle without a target cycle, no request is made, and a later complete sequence still makes exactly one.
- R8: With `TOP_BOOT`=1, the boot range is 1E000h–1FFFFh. With `TOP_BOOT`=0, it is 00000h–01FFFh.
- R9: While locked, a target inside the boot range makes no request and the sequencer still returns to read mode. Targets outside the range are programmed normally.
- R10: Reset leaves the lock clear. A one-clock `lock_set` pulse sets it and a one-clock `lock_clr` pulse clears it; if both arrive together, set wins. `boot_locked` shows the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| addr | input | 17 | Byte address bus |
| din | input | 8 | Write data bus |
| lock_set | input | 1 | Single-clock pulse that locks the boot block |
| lock_clr | input | 1 | Single-clock pulse that unlocks the boot block |
| rd_drive | output | 1 | Enable for the tri-state data output drivers |
| pgm_req | output | 1 | Single-clock program request to the array |
| pgm_addr | output | 17 | Target address of the program request |
| pgm_data | output | 8 | Data byte of the program request |
| boot_locked | output | 1 | Boot block lock flag |

## Verification
The command sequencer is internal and can only be seen through `pgm_req`. A wrong state therefore shows up only at the end of the next target cycle, as a missing request, an extra request, or a request with the wrong address or data. To catch that, the bench follows every pass through the sequence, including sequences that are abandoned or left partial, with a check on the request pulse. A wrong decision on the read qualifier shows on `rd_drive` within four clocks of the strobe change that should have set or cleared it. The strobe orderings that latch the address and the data are tested with the bus deliberately changed between the two capture points, so a capture at the wrong edge returns a different value.

// File: rtl/pflash_bus_ctrl.sv
module pflash_bus_ctrl #(
  parameter int AW           = 17,
  parameter int DW           = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int BOOT_SECTORS = 16,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          lock_set,
  input  logic          lock_clr,
  output logic          rd_drive,
  output logic          pgm_req,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data,
  output logic          boot_locked
);
  localparam int BOOT_LSB = $clog2(SECTOR_BYTES * BOOT_SECTORS);
  localparam logic [AW-1:0] KEY_A1 = AW'('h5555);
  localparam logic [AW-1:0] KEY_A2 = AW'('h2AAA);
  localparam logic [DW-1:0] KEY_D1 = DW'('hAA);
  localparam logic [DW-1:0] KEY_D2 = DW'('h55);
  localparam logic [DW-1:0] KEY_PG = DW'('hA0);

  typedef enum logic [1:0] {S_READ, S_KEY1, S_KEY2, S_SETUP} seq_t;

  logic [2:0] strb_q1, strb_s;
  logic ce_s, oe_s, we_s;
  logic rd_qual, wr_prev;
  logic wr_now, wr_start, wr_end;
  logic [AW-1:0] addr_lat;
  logic boot_hit;
  seq_t st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      strb_q1 <= 3'b111;
      strb_s  <= 3'b111;
    end else begin
      strb_q1 <= {ce_n, oe_n, we_n};
      strb_s  <= strb_q1;
    end

  assign {ce_s, oe_s, we_s} = strb_s;
  assign wr_now   = ~ce_s & ~we_s;
  assign wr_start = wr_now & ~wr_prev;
  assign wr_end   = ~wr_now & wr_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_qual  <= 1'b0;
      rd_drive <= 1'b0;
    end else begin
      if (ce_s | oe_s)  rd_qual <= we_s;
      else if (!we_s)   rd_qual <= 1'b0;
      rd_drive <= ~ce_s & ~oe_s & we_s & rd_qual;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_prev  <= 1'b0;
      addr_lat <= '0;
    end else begin
      wr_prev <= wr_now;
      if (wr_start) addr_lat <= addr;
    end

  generate
    if (TOP_BOOT) begin : g_top_boot
      assign boot_hit = &addr_lat[AW-1:BOOT_LSB];
    end else begin : g_bot_boot
      assign boot_hit = ~|addr_lat[AW-1:BOOT_LSB];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        boot_locked <= 1'b0;
    else if (lock_set) boot_locked <= 1'b1;
    else if (lock_clr) boot_locked <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_READ;
      pgm_req  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
    end else begin
      pgm_req <= 1'b0;
      if (wr_end) begin
        st <= S_READ;
        unique case (st)
          S_READ:  if (addr_lat == KEY_A1 && din == KEY_D1) st <= S_KEY1;
          S_KEY1:  if (addr_lat == KEY_A2 && din == KEY_D2) st <= S_KEY2;
          S_KEY2:  if (addr_lat == KEY_A1 && din == KEY_PG) st <= S_SETUP;
          S_SETUP: if (!(boot_locked && boot_hit)) begin
                     pgm_req  <= 1'b1;
                     pgm_addr <= addr_lat;
                     pgm_data <= din;
                   end
          default: st <= S_READ;
        endcase
      end
    end

  function automatic logic in_boot(input logic [AW-1:0] a);
    return TOP_BOOT ? (&a[AW-1:BOOT_LSB]) : (~|a[AW-1:BOOT_LSB]);
  endfunction

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);
  p_req_from_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> ($past(st) == S_SETUP && st == S_READ));
  p_seq_on_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> $past(wr_end));
  p_locked_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> !($past(boot_locked) && in_boot(pgm_addr)));
  p_lock_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_clr && !lock_set) |=> !boot_locked);
  p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |=> !rd_drive);
endmodule

// File: tb/pflash_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module pflash_bus_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic lock_set = 1'b0, lock_clr = 1'b0;
  logic rd_t, req_t, lk_t, rd_b, req_b, lk_b;
  logic [16:0] pa_t, pa_b;
  logic [7:0]  pd_t, pd_b;
  int n_vec = 0, n_bad = 0;
  int cnt_t = 0, cnt_b = 0;
  logic [16:0] last_a_t, last_a_b;
  logic [7:0]  last_d_t, last_d_b;

  always #4 clk = ~clk;

  pflash_bus_ctrl #(.TOP_BOOT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .lock_set(lock_set), .lock_clr(lock_clr),
    .rd_drive(rd_t), .pgm_req(req_t), .pgm_addr(pa_t), .pgm_data(pd_t),
    .boot_locked(lk_t));

  pflash_bus_ctrl #(.TOP_BOOT(1'b0)) dut_bot_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .lock_set(lock_set), .lock_clr(lock_clr),
    .rd_drive(rd_b), .pgm_req(req_b), .pgm_addr(pa_b), .pgm_data(pd_b),
    .boot_locked(lk_b));

  always @(negedge clk) begin
    if (req_t) begin cnt_t++; last_a_t = pa_t; last_d_t = pd_t; end
    if (req_b) begin cnt_b++; last_a_b = pa_b; last_d_b = pd_b; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ctl=0: WE falls last and rises first; ctl=1: CE does
  task automatic bus_wr(input logic [16:0] a, input logic [7:0] d, input bit ctl);
    addr = a; din = ~d;
    if (ctl) we_n = 1'b0; else ce_n = 1'b0;
    cyc(4);
    if (ctl) ce_n = 1'b0; else we_n = 1'b0;
    cyc(5);
    addr = ~a; din = d;
    cyc(5);
    if (ctl) ce_n = 1'b1; else we_n = 1'b1;
    cyc(5);
    din = ~d;
    if (ctl) we_n = 1'b1; else ce_n = 1'b1;
    cyc(4);
  endtask

  task automatic unlock(input bit ctl);
    bus_wr(17'h05555, 8'hAA, ctl);
    bus_wr(17'h02AAA, 8'h55, ctl);
    bus_wr(17'h05555, 8'hA0, ctl);
  endtask

  task automatic pulse_lock(input bit set, input bit clr);
    lock_set = set; lock_clr = clr;
    cyc(1);
    lock_set = 1'b0; lock_clr = 1'b0;
    cyc(1);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // reset state
    chk(!rd_t && !rd_b, "R1 reset rd_drive", rd_t, 0);
    chk(!req_t && !req_b, "R5 reset pgm_req", req_t, 0);
    chk(!lk_t && !lk_b, "R10 reset lock", lk_t, 0);

    // R1/R2 normal read and its end via OE, then via CE
    ce_n = 1'b0; oe_n = 1'b0; cyc(5);
    chk(rd_t && rd_b, "R1 read drive", rd_t, 1);
    oe_n = 1'b1; cyc(4);
    chk(!rd_t, "R2 OE end", rd_t, 0);
    oe_n = 1'b0; cyc(5);
    chk(rd_t, "R1 read again", rd_t, 1);
    ce_n = 1'b1; cyc(4);
    chk(!rd_t, "R2 CE end", rd_t, 0);
    // R3 standby regardless of OE
    for (int k = 0; k < 2; k++) begin
      oe_n = k[0]; cyc(6);
      chk(!rd_t && !rd_b, "R3 standby", rd_t, 0);
    end
    oe_n = 1'b1; cyc(4);
    // R1 WE low before CE/OE go low
    we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; cyc(5);
    we_n = 1'b1; cyc(6);
    chk(!rd_t, "R1 WE late high", rd_t, 0);
    oe_n = 1'b1; cyc(4); oe_n = 1'b0; cyc(5);
    chk(rd_t, "R1 requalified", rd_t, 1);
    // R1 WE dips mid read
    we_n = 1'b0; cyc(5);
    chk(!rd_t, "R1 WE dip", rd_t, 0);
    we_n = 1'b1; cyc(6);
    chk(!rd_t, "R1 stays off", rd_t, 0);
    ce_n = 1'b1; oe_n = 1'b1; cyc(4);

    // R6 mismatch after first unlock cycle
    cnt_t = 0; cnt_b = 0;
    bus_wr(17'h05555, 8'hAA, 1'b0);
    bus_wr(17'h05555, 8'hFF, 1'b0);
    bus_wr(17'h02AAA, 8'h55, 1'b0);
    bus_wr(17'h05555, 8'hA0, 1'b0);
    bus_wr(17'h00123, 8'h3C, 1'b0);
    cyc(4);
    chk(cnt_t == 0 && cnt_b == 0, "R6 abandon early", cnt_t, 0);
    // R6 mismatch at setup step
    bus_wr(17'h05555, 8'hAA, 1'b1);
    bus_wr(17'h02AAA, 8'h55, 1'b1);
    bus_wr(17'h05555, 8'hFF, 1'b1);
    bus_wr(17'h00456, 8'h5A, 1'b1);
    cyc(4);
    chk(cnt_t == 0, "R6 abandon setup", cnt_t, 0);
    // R7 partial sequence then read, then a full one
    unlock(1'b0);
    ce_n = 1'b0; oe_n = 1'b0; cyc(6);
    chk(rd_t && cnt_t == 0, "R7 no request on partial", cnt_t, 0);
    ce_n = 1'b1; oe_n = 1'b1; cyc(4);
    // target consumed by setup state left pending; it must program once
    bus_wr(17'h00777, 8'h81, 1'b0);
    cyc(4);
    chk(cnt_t == 1 && last_a_t == 17'h00777, "R7 pending setup target", last_a_t, 17'h00777);
    cnt_t = 0; cnt_b = 0;
    bus_wr(17'h00999, 8'h42, 1'b1);
    cyc(4);
    chk(cnt_t == 0, "R5 back in read mode", cnt_t, 0);

    // R10 lock pulses
    pulse_lock(1'b1, 1'b0);
    chk(lk_t && lk_b, "R10 lock set", lk_t, 1);
    pulse_lock(1'b0, 1'b1);
    chk(!lk_t, "R10 lock clr", lk_t, 0);
    pulse_lock(1'b1, 1'b1);
    chk(lk_t, "R10 set wins", lk_t, 1);
    pulse_lock(1'b0, 1'b1);

    // R4 R5 R8 R9 sweep
    for (int lk = 0; lk < 2; lk++) begin
      if (lk == 1) pulse_lock(1'b1, 1'b0);
      for (int i = 0; i < 32; i++) begin
        logic [16:0] a;
        logic [7:0] d;
        bit bt, bb, bit_ctl;
        if (i < 8)       a = 17'(i * 1024 + i);
        else if (i < 16) a = 17'h1E000 + 17'((i - 8) * 1024 + i);
        else             a = 17'((i * 5381) % 131072);
        d = 8'((i * 37 + 5 + lk * 11) % 256);
        bit_ctl = i[0] ^ lk[0];
        bt = (a >= 17'h1E000);
        bb = (a < 17'h02000);
        cnt_t = 0; cnt_b = 0;
        unlock(bit_ctl);
        bus_wr(a, d, bit_ctl);
        cyc(4);
        chk(cnt_t == ((lk == 1 && bt) ? 0 : 1), "R9 R8 top request count", cnt_t, (lk == 1 && bt) ? 0 : 1);
        chk(cnt_b == ((lk == 1 && bb) ? 0 : 1), "R9 R8 bottom request count", cnt_b, (lk == 1 && bb) ? 0 : 1);
        if (cnt_t == 1)
          chk(last_a_t == a && last_d_t == d, "R4 R5 top addr/data", {last_a_t, last_d_t}, {a, d});
        if (cnt_b == 1)
          chk(last_a_b == a && last_d_b == d, "R4 R5 bottom addr/data", {last_a_b, last_d_b}, {a, d});
        // the sequencer must be back in read mode: a lone write makes nothing
        bus_wr(a, d, bit_ctl);
        cyc(4);
        chk(cnt_t <= 1 && cnt_b <= 1 && cnt_t == ((lk == 1 && bt) ? 0 : 1), "R9 R5 return to read", cnt_t, (lk == 1 && bt) ? 0 : 1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule